// File: doc/BRIEF.md
# Two-Port Mailbox Memory

A synchronous two-port word store that lets two agents exchange data and signal each other. The two ports are called left and right. Each has its own select, read/write direction, output enable, two byte-lane enables, address and data buses, so either side can read or write any word in any cycle. Both ports sample their requests on the rising edge of one shared clock. Read data comes back one cycle later, together with a valid strobe.

The two highest words of the store also act as doorbells. When the right port writes the word one below the top, the left side's active-low interrupt goes low. The left side clears it by selecting that word with its output enable low. In the same way, a left write to the top word raises the right side's interrupt, and the right side clears it by selecting the top word with output enable low. The doorbell words keep their full 16-bit contents like any other word. Depth is a parameter (2048 words by default, a power of two, 16384 in the largest build). The address width and both doorbell addresses follow from it.

Top module: `twin_port_mailbox_ram`

## Requirements
- R1: A port writes when sel_n=0, rw=0 and at least one lane enable is low. ub_n=0 enables bits 15:8 and lb_n=0 enables bits 7:0. Only the enabled lanes of the addressed word change.
- R2: A port reads when sel_n=0, rw=1, oe_n=0 and at least one lane enable is low. One cycle later rvalid is 1, the enabled lanes of rdata hold the stored bytes, and the disabled lanes are zero.
- R3: If a port is deselected (sel_n=1), or has oe_n=1 with rw=1, or is writing, or has both lane enables high, then in the next cycle its rvalid is 0 and its rdata is all zero. A deselected port changes no stored word.
- R4: The two ports work independently. Both may read the same word in the same cycle, and both then return its contents.
- R5: When both ports write the same word in the same cycle, a lane enabled by both takes the left data. A lane enabled by only one port takes that port's data.
- R6: A read and a write to the same word in the same cycle, from either port, return the word's contents before the write.
- R7: A right-port write to address DEPTH-2 drives lt_irq_n low in the next cycle. A left-port access to DEPTH-2 with sel_n=0 and oe_n=0 drives it high in the next cycle, whatever rw and the lane enables are.
- R8: A left-port write to address DEPTH-1 drives rt_irq_n low in the next cycle. A right-port access to DEPTH-1 with sel_n=0 and oe_n=0 drives it high in the next cycle, whatever rw is.
- R9: Reset leaves both interrupts high and both rvalid low. If a set and a clear of the same interrupt occur in the same cycle, the interrupt goes low. With neither, the interrupt holds its value.
- R10: The doorbell words store and return data like ordinary words. A port that writes its own receiving doorbell word (left at DEPTH-2, right at DEPTH-1) raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lt_sel_n | input | 1 | Left select, active low |
| lt_rw | input | 1 | Left direction, 1 = read, 0 = write |
| lt_oe_n | input | 1 | Left output enable, active low |
| lt_ub_n | input | 1 | Left upper lane enable, active low |
| lt_lb_n | input | 1 | Left lower lane enable, active low |
| lt_addr | input | AW | Left word address, AW = log2(DEPTH) |
| lt_wdata | input | 2*LANE_W | Left write data |
| lt_rdata | output | 2*LANE_W | Left read data, disabled lanes zero |
| lt_rvalid | output | 1 | Left read data valid |
| lt_irq_n | output | 1 | Left interrupt, active low |
| rt_sel_n | input | 1 | Right select, active low |
| rt_rw | input | 1 | Right direction, 1 = read, 0 = write |
| rt_oe_n | input | 1 | Right output enable, active low |
| rt_ub_n | input | 1 | Right upper lane enable, active low |
| rt_lb_n | input | 1 | Right lower lane enable, active low |
| rt_addr | input | AW | Right word address |
| rt_wdata | input | 2*LANE_W | Right write data |
| rt_rdata | output | 2*LANE_W | Right read data, disabled lanes zero |
| rt_rvalid | output | 1 | Right read data valid |
| rt_irq_n | output | 1 | Right interrupt, active low |

## Verification
The assertions check, on every cycle, the interrupt set, clear, priority and hold rules, the link between a read request and the next cycle's valid strobe, and the zeroing of data when no read happens or a lane is disabled. Stored contents cannot be seen by a single-cycle property. Lane-masked writes, left priority on colliding writes, read-before-write on the same word, and ignored writes while deselected only appear through the bench's write-then-read scenarios, which it compares against its own shadow copy of the store.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
   localparam int LANES = 2;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

   // active-high lane mask from the two active-low lane enables, upper lane first
   function automatic logic [LANES-1:0] lane_mask(input logic ub_n, input logic lb_n);
      return {~ub_n, ~lb_n};
   endfunction
endpackage

// File: rtl/mbx_port_dec.sv
`timescale 1ns/1ps
module mbx_port_dec #(
   parameter int             AW        = 11,
   parameter logic [AW-1:0]  SEND_ADDR = '1,
   parameter logic [AW-1:0]  TAKE_ADDR = '0
) (
   input  logic                      sel_n,
   input  logic                      rw,
   input  logic                      oe_n,
   input  logic                      ub_n,
   input  logic                      lb_n,
   input  logic [AW-1:0]             addr,
   output mbx_pkg::op_e              op,
   output logic [mbx_pkg::LANES-1:0] lanes,
   output logic                      send,
   output logic                      take
);
   import mbx_pkg::*;

   logic any_lane;

   always_comb begin
      lanes    = lane_mask(ub_n, lb_n);
      any_lane = |lanes;
      if (!sel_n && !rw && any_lane)
         op = OP_WRITE;
      else if (!sel_n && rw && !oe_n && any_lane)
         op = OP_READ;
      else
         op = OP_NONE;
      send = (op == OP_WRITE) && (addr == SEND_ADDR);
      take = !sel_n && !oe_n && (addr == TAKE_ADDR);
   end
endmodule

// File: rtl/mbx_store.sv
`timescale 1ns/1ps
module mbx_store #(
   parameter int DEPTH  = 2048,
   parameter int LANE_W = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int DW    = mbx_pkg::LANES * LANE_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   // port a: priority writer
   input  logic                      a_we,
   input  logic                      a_rd,
   input  logic [mbx_pkg::LANES-1:0] a_lanes,
   input  logic [AW-1:0]             a_addr,
   input  logic [DW-1:0]             a_wdata,
   output logic [DW-1:0]             a_rdata,
   output logic                      a_rvalid,
   // port b
   input  logic                      b_we,
   input  logic                      b_rd,
   input  logic [mbx_pkg::LANES-1:0] b_lanes,
   input  logic [AW-1:0]             b_addr,
   input  logic [DW-1:0]             b_wdata,
   output logic [DW-1:0]             b_rdata,
   output logic                      b_rvalid
);
   import mbx_pkg::*;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      logic [LANE_W-1:0] a_q, b_q;

      // b first, a last: a wins a shared word on a shared lane
      always_ff @(posedge clk) begin
         if (b_we && b_lanes[g]) cells[b_addr] <= b_wdata[g*LANE_W +: LANE_W];
         if (a_we && a_lanes[g]) cells[a_addr] <= a_wdata[g*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
         end else begin
            a_q <= (a_rd && a_lanes[g]) ? cells[a_addr] : '0;
            b_q <= (b_rd && b_lanes[g]) ? cells[b_addr] : '0;
         end
      end

      assign a_rdata[g*LANE_W +: LANE_W] = a_q;
      assign b_rdata[g*LANE_W +: LANE_W] = b_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_rvalid <= 1'b0;
         b_rvalid <= 1'b0;
      end else begin
         a_rvalid <= a_rd;
         b_rvalid <= b_rd;
      end
   end
endmodule

// File: rtl/mbx_flag.sv
`timescale 1ns/1ps
module mbx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag_n <= 1'b1;
      else if (set) flag_n <= 1'b0;
      else if (clr) flag_n <= 1'b1;
   end
endmodule

// File: rtl/twin_port_mailbox_ram.sv
`timescale 1ns/1ps
module twin_port_mailbox_ram #(
   parameter int DEPTH  = 2048,
   parameter int LANE_W = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int DW    = mbx_pkg::LANES * LANE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lt_sel_n,
   input  logic          lt_rw,
   input  logic          lt_oe_n,
   input  logic          lt_ub_n,
   input  logic          lt_lb_n,
   input  logic [AW-1:0] lt_addr,
   input  logic [DW-1:0] lt_wdata,
   output logic [DW-1:0] lt_rdata,
   output logic          lt_rvalid,
   output logic          lt_irq_n,
   input  logic          rt_sel_n,
   input  logic          rt_rw,
   input  logic          rt_oe_n,
   input  logic          rt_ub_n,
   input  logic          rt_lb_n,
   input  logic [AW-1:0] rt_addr,
   input  logic [DW-1:0] rt_wdata,
   output logic [DW-1:0] rt_rdata,
   output logic          rt_rvalid,
   output logic          rt_irq_n
);
   import mbx_pkg::*;

   localparam logic [AW-1:0] BOX_LO = AW'(DEPTH - 2);
   localparam logic [AW-1:0] BOX_HI = AW'(DEPTH - 1);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("LANE_W must be at least 1");
   end

   op_e              lt_op, rt_op;
   logic [LANES-1:0] lt_lanes, rt_lanes;
   logic             lt_send, lt_take, rt_send, rt_take;

   mbx_port_dec #(.AW(AW), .SEND_ADDR(BOX_HI), .TAKE_ADDR(BOX_LO)) u_lt_dec (
      .sel_n(lt_sel_n), .rw(lt_rw), .oe_n(lt_oe_n), .ub_n(lt_ub_n), .lb_n(lt_lb_n),
      .addr(lt_addr), .op(lt_op), .lanes(lt_lanes), .send(lt_send), .take(lt_take));

   mbx_port_dec #(.AW(AW), .SEND_ADDR(BOX_LO), .TAKE_ADDR(BOX_HI)) u_rt_dec (
      .sel_n(rt_sel_n), .rw(rt_rw), .oe_n(rt_oe_n), .ub_n(rt_ub_n), .lb_n(rt_lb_n),
      .addr(rt_addr), .op(rt_op), .lanes(rt_lanes), .send(rt_send), .take(rt_take));

   mbx_store #(.DEPTH(DEPTH), .LANE_W(LANE_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .a_we(lt_op == OP_WRITE), .a_rd(lt_op == OP_READ), .a_lanes(lt_lanes),
      .a_addr(lt_addr), .a_wdata(lt_wdata), .a_rdata(lt_rdata), .a_rvalid(lt_rvalid),
      .b_we(rt_op == OP_WRITE), .b_rd(rt_op == OP_READ), .b_lanes(rt_lanes),
      .b_addr(rt_addr), .b_wdata(rt_wdata), .b_rdata(rt_rdata), .b_rvalid(rt_rvalid));

   // left doorbell: rung by the right port, answered by the left port
   mbx_flag u_lt_flag (.clk(clk), .rst_n(rst_n), .set(rt_send), .clr(lt_take), .flag_n(lt_irq_n));
   // right doorbell: rung by the left port, answered by the right port
   mbx_flag u_rt_flag (.clk(clk), .rst_n(rst_n), .set(lt_send), .clr(rt_take), .flag_n(rt_irq_n));
endmodule

// File: rtl/mbx_chk.sv
`timescale 1ns/1ps
module mbx_chk #(
   parameter int DEPTH  = 2048,
   parameter int LANE_W = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int DW    = 2 * LANE_W
) (
   input logic          clk,
   input logic          rst_n,
   input logic          lt_sel_n, lt_rw, lt_oe_n, lt_ub_n, lt_lb_n,
   input logic [AW-1:0] lt_addr,
   input logic [DW-1:0] lt_rdata,
   input logic          lt_rvalid,
   input logic          lt_irq_n,
   input logic          rt_sel_n, rt_rw, rt_oe_n, rt_ub_n, rt_lb_n,
   input logic [AW-1:0] rt_addr,
   input logic [DW-1:0] rt_rdata,
   input logic          rt_rvalid,
   input logic          rt_irq_n
);
   localparam logic [AW-1:0] BOX_LO = AW'(DEPTH - 2);
   localparam logic [AW-1:0] BOX_HI = AW'(DEPTH - 1);

   logic lt_wr, lt_rd, rt_wr, rt_rd, lt_set, lt_clr, rt_set, rt_clr;
   assign lt_wr  = !lt_sel_n && !lt_rw && (!lt_ub_n || !lt_lb_n);
   assign rt_wr  = !rt_sel_n && !rt_rw && (!rt_ub_n || !rt_lb_n);
   assign lt_rd  = !lt_sel_n && lt_rw && !lt_oe_n && (!lt_ub_n || !lt_lb_n);
   assign rt_rd  = !rt_sel_n && rt_rw && !rt_oe_n && (!rt_ub_n || !rt_lb_n);
   assign lt_set = rt_wr && rt_addr == BOX_LO;
   assign lt_clr = !lt_sel_n && !lt_oe_n && lt_addr == BOX_LO;
   assign rt_set = lt_wr && lt_addr == BOX_HI;
   assign rt_clr = !rt_sel_n && !rt_oe_n && rt_addr == BOX_HI;

   AST_LT_RING:    assert property (@(posedge clk) disable iff (!rst_n) lt_set |=> !lt_irq_n);            // R7
   AST_LT_ANSWER:  assert property (@(posedge clk) disable iff (!rst_n) lt_clr && !lt_set |=> lt_irq_n);  // R7
   AST_RT_RING:    assert property (@(posedge clk) disable iff (!rst_n) rt_set |=> !rt_irq_n);            // R8
   AST_RT_ANSWER:  assert property (@(posedge clk) disable iff (!rst_n) rt_clr && !rt_set |=> rt_irq_n);  // R8
   AST_LT_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !lt_set && !lt_clr |=> $stable(lt_irq_n)); // R9
   AST_RT_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !rt_set && !rt_clr |=> $stable(rt_irq_n)); // R9
   AST_LT_VALID:   assert property (@(posedge clk) disable iff (!rst_n) lt_rd |=> lt_rvalid);              // R2
   AST_RT_VALID:   assert property (@(posedge clk) disable iff (!rst_n) rt_rd |=> rt_rvalid);              // R2
   AST_LT_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !lt_rd |=> !lt_rvalid && lt_rdata == '0); // R3
   AST_RT_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !rt_rd |=> !rt_rvalid && rt_rdata == '0); // R3
   AST_LT_LANE_MUTE: assert property (@(posedge clk) disable iff (!rst_n) lt_ub_n |=> lt_rdata[DW-1:LANE_W] == '0); // R2
   AST_RT_LANE_MUTE: assert property (@(posedge clk) disable iff (!rst_n) rt_lb_n |=> rt_rdata[LANE_W-1:0] == '0);  // R2
endmodule

bind twin_port_mailbox_ram mbx_chk #(.DEPTH(DEPTH), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/sim_twin_port_mailbox_ram.sv
`timescale 1ns/1ps
module sim_twin_port_mailbox_ram;
   localparam int DEPTH = 2048;
   localparam int AW    = $clog2(DEPTH);
   localparam int DW    = 16;
   localparam logic [AW-1:0] BOX_LO = AW'(DEPTH - 2);
   localparam logic [AW-1:0] BOX_HI = AW'(DEPTH - 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic lt_sel_n, lt_rw, lt_oe_n, lt_ub_n, lt_lb_n, rt_sel_n, rt_rw, rt_oe_n, rt_ub_n, rt_lb_n;
   logic [AW-1:0] lt_addr, rt_addr;
   logic [DW-1:0] lt_wdata, rt_wdata, lt_rdata, rt_rdata;
   logic lt_rvalid, rt_rvalid, lt_irq_n, rt_irq_n;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [DW-1:0] shadow [DEPTH];
   logic exp_lt_irq = 1'b1, exp_rt_irq = 1'b1;

   always #2.5 clk = ~clk;

   twin_port_mailbox_ram #(.DEPTH(DEPTH), .LANE_W(8)) u0 (.*);

   function automatic logic [DW-1:0] mask(input logic ub_n, input logic lb_n);
      return {{8{~ub_n}}, {8{~lb_n}}};
   endfunction
   function automatic logic is_wr(input logic s, input logic rw, input logic u, input logic l);
      return !s && !rw && (!u || !l);
   endfunction
   function automatic logic is_rd(input logic s, input logic rw, input logic o, input logic u, input logic l);
      return !s && rw && !o && (!u || !l);
   endfunction

   task automatic lp(input logic s, input logic rw, input logic o, input logic u, input logic l,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
      lt_sel_n = s; lt_rw = rw; lt_oe_n = o; lt_ub_n = u; lt_lb_n = l; lt_addr = a; lt_wdata = d;
   endtask
   task automatic rp(input logic s, input logic rw, input logic o, input logic u, input logic l,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
      rt_sel_n = s; rt_rw = rw; rt_oe_n = o; rt_ub_n = u; rt_lb_n = l; rt_addr = a; rt_wdata = d;
   endtask
   task automatic idle();
      lp(1, 1, 1, 1, 1, '0, '0);
      rp(1, 1, 1, 1, 1, '0, '0);
   endtask

   task automatic check(input string tag, input string what, input logic [DW:0] got, input logic [DW:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
      end
   endtask

   // one request cycle: model the expected outcome, let the edge pass, compare
   task automatic step(input string tag);
      logic lw, lr, rw_, rr, lset, lclr, rset, rclr;
      logic [DW-1:0] el, er, m;
      lw = is_wr(lt_sel_n, lt_rw, lt_ub_n, lt_lb_n);
      rw_ = is_wr(rt_sel_n, rt_rw, rt_ub_n, rt_lb_n);
      lr = is_rd(lt_sel_n, lt_rw, lt_oe_n, lt_ub_n, lt_lb_n);
      rr = is_rd(rt_sel_n, rt_rw, rt_oe_n, rt_ub_n, rt_lb_n);
      el = lr ? (shadow[lt_addr] & mask(lt_ub_n, lt_lb_n)) : '0;
      er = rr ? (shadow[rt_addr] & mask(rt_ub_n, rt_lb_n)) : '0;
      lset = rw_ && rt_addr == BOX_LO;
      lclr = !lt_sel_n && !lt_oe_n && lt_addr == BOX_LO;
      rset = lw && lt_addr == BOX_HI;
      rclr = !rt_sel_n && !rt_oe_n && rt_addr == BOX_HI;
      if (rw_) begin
         m = mask(rt_ub_n, rt_lb_n);
         shadow[rt_addr] = (shadow[rt_addr] & ~m) | (rt_wdata & m);
      end
      if (lw) begin
         m = mask(lt_ub_n, lt_lb_n);
         shadow[lt_addr] = (shadow[lt_addr] & ~m) | (lt_wdata & m);
      end
      exp_lt_irq = lset ? 1'b0 : lclr ? 1'b1 : exp_lt_irq;
      exp_rt_irq = rset ? 1'b0 : rclr ? 1'b1 : exp_rt_irq;
      @(negedge clk);
      check(tag, "left {rvalid,rdata}", {lt_rvalid, lt_rdata}, {lr, el});
      check(tag, "right {rvalid,rdata}", {rt_rvalid, rt_rdata}, {rr, er});
      check(tag, "{lt_irq_n,rt_irq_n}", {15'd0, lt_irq_n, rt_irq_n}, {15'd0, exp_lt_irq, exp_rt_irq});
   endtask

   function automatic logic [AW-1:0] pick();
      int k = $urandom % 10;
      return (k == 8) ? BOX_LO : (k == 9) ? BOX_HI : AW'(k);
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL RUN watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      check("R9", "reset {lt_irq_n,rt_irq_n,lt_rvalid,rt_rvalid}",
            {13'd0, lt_irq_n, rt_irq_n, lt_rvalid, rt_rvalid}, {13'd0, 1'b1, 1'b1, 1'b0, 1'b0});

      // prefill; R10 own receiving doorbell writes ring nothing
      for (int a = 0; a < 8; a++) begin
         idle(); lp(0, 0, 1, 0, 0, AW'(a), 16'h1111 * (a + 1)); step("R1");
      end
      idle(); lp(0, 0, 1, 0, 0, BOX_LO, 16'hC0DE); step("R10");
      idle(); rp(0, 0, 1, 0, 0, BOX_HI, 16'hBEEF); step("R10");
      idle(); lp(0, 1, 1, 0, 0, BOX_HI, '0); rp(0, 1, 1, 0, 0, BOX_LO, '0); step("R10");

      // R2 reads with lane selections
      idle(); lp(0, 1, 0, 0, 0, 2, '0); step("R2");
      idle(); lp(0, 1, 0, 0, 1, 2, '0); rp(0, 1, 0, 1, 0, 5, '0); step("R2");
      // R1 upper-lane write then readback
      idle(); lp(0, 0, 1, 0, 1, 1, 16'hABCD); step("R1");
      idle(); lp(0, 1, 0, 0, 0, 1, '0); step("R1");
      // R3 ignored requests
      idle(); lp(1, 0, 0, 0, 0, 3, 16'hDEAD); rp(0, 1, 1, 0, 0, 3, '0); step("R3");
      idle(); lp(0, 1, 0, 1, 1, 3, '0); rp(0, 1, 0, 0, 0, 3, '0); step("R3");
      // R4 same word, both ports
      idle(); lp(0, 1, 0, 0, 0, 4, '0); rp(0, 1, 0, 0, 0, 4, '0); step("R4");
      // R5 colliding writes
      idle(); lp(0, 0, 1, 0, 0, 6, 16'h1234); rp(0, 0, 1, 0, 0, 6, 16'h5678); step("R5");
      idle(); lp(0, 0, 1, 1, 0, 6, 16'hAAAA); rp(0, 0, 1, 0, 0, 6, 16'h9955); step("R5");
      idle(); lp(0, 1, 0, 0, 0, 6, '0); step("R5");
      // R6 read-before-write across ports
      idle(); lp(0, 0, 1, 0, 0, 0, 16'h0F0F); rp(0, 1, 0, 0, 0, 0, '0); step("R6");
      idle(); rp(0, 1, 0, 0, 0, 0, '0); step("R6");
      // R8 ring right, answer with a read
      idle(); lp(0, 0, 1, 0, 0, BOX_HI, 16'h7777); step("R8");
      idle(); step("R8");
      idle(); rp(0, 1, 0, 0, 0, BOX_HI, '0); step("R8");
      // R7 ring left, answer with rw low and no lanes (no write)
      idle(); rp(0, 0, 1, 0, 0, BOX_LO, 16'h4242); step("R7");
      idle(); lp(0, 0, 0, 1, 1, BOX_LO, '0); step("R7");
      idle(); lp(0, 1, 0, 0, 0, BOX_LO, '0); step("R10");
      // R9 ring and answer in one cycle: ring wins
      idle(); rp(0, 0, 1, 0, 0, BOX_LO, 16'h0001); lp(0, 1, 0, 0, 0, BOX_LO, '0); step("R9");
      idle(); lp(0, 0, 1, 0, 0, BOX_HI, 16'h0002); rp(0, 1, 0, 0, 0, BOX_HI, '0); step("R9");

      // constrained random mix over a small address pool
      for (int n = 0; n < 3000; n++) begin
         lp(($urandom % 5) == 0, $urandom % 2, ($urandom % 4) == 0, $urandom % 2, $urandom % 2,
            pick(), DW'($urandom));
         rp(($urandom % 5) == 0, $urandom % 2, ($urandom % 4) == 0, $urandom % 2, $urandom % 2,
            pick(), DW'($urandom));
         step("R4 random");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule